// File: doc/BRIEF.md
# Two-State Batch Scheduler

This block sits between per-source request FIFOs, which group requests into row-local batches, and a set of per-bank request queues. It alternates between two states. In the pick state it looks only at sources whose head batch is marked ready and chooses one of them. In the drain state it moves that batch, one request per cycle, into the queue of the bank each request targets.

The choice in the pick state follows one of two rules. The fewest-outstanding rule favours the source with the smallest count of in-flight requests. The rotation rule takes sources in turn. A free-running linear feedback shift register provides a fresh pseudo-random value on every cycle. The value present in the pick cycle is compared with a run-time probability input, and that comparison decides which rule applies to the pick. Software can therefore weight scheduling toward latency-sensitive sources or toward fair progress for bandwidth-heavy ones.

The per-source in-flight counts come in from outside. The block does not form batches and does not track DRAM timing.

Top module: `batch_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no dequeue strobe and no output valid is raised. The block starts in the pick state, and its rotation pointer starts at source 0.
- R2: A pick occurs only in a pick-state cycle in which at least one `src_ready` bit is set, and it selects a source whose bit is set. With no source ready, the block stays idle and raises no strobe.
- R3: Under the fewest-outstanding rule, the chosen source has the smallest `src_infl` value among the ready sources. Equal values go to the lowest source index. A `sjf_prob` of all ones (255) forces this rule on every pick.
- R4: Under the rotation rule, the chosen source is the first ready source at or after the rotation pointer, searching upward with wrap-around. After every pick, whichever rule made it, the pointer moves to the source one above the chosen one. A `sjf_prob` of 0 forces this rule on every pick.
- R5: The fewest-outstanding rule applies when the register value in the pick cycle is less than or equal to `sjf_prob`, and the rotation rule applies otherwise. The register never holds zero. With an intermediate probability, each pick matches one of the two rules' choices, and over many picks both rules occur.
- R6: A picked batch of length L (the `src_len` value in the pick cycle, with 0 counted as 1) produces exactly L dequeue strobes to the chosen source, at most one per cycle. The first strobe comes in the cycle after the pick. After the last strobe, one pick cycle follows with no strobe.
- R7: Only the head batch of each source is scheduled. `src_len` of the draining source is ignored during the drain, and a second batch from the same source needs a new pick.
- R8: While `bank_full` is set for the bank of the current head request of the draining source, no strobe and no output valid are raised. The drain resumes with the same request once that bit clears.
- R9: In every cycle with `out_valid` set, `out_src`, `out_bank` and `out_tag` equal the draining source's index and its head request's bank and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ready | input | NSRC | Head batch of each source is complete |
| src_len | input | NSRC*LEN_W | Head batch length per source |
| src_infl | input | NSRC*CNT_W | In-flight request count per source |
| src_bank | input | NSRC*BANK_W | Target bank of each source's head request |
| src_tag | input | NSRC*TAG_W | Payload tag of each source's head request |
| sjf_prob | input | RND_W | Probability threshold for the fewest-outstanding rule |
| bank_full | input | NBANK | Per-bank queue full flags |
| src_deq | output | NSRC | One-hot dequeue strobe to the source FIFOs |
| out_valid | output | 1 | Request pushed to a bank queue this cycle |
| out_src | output | SRC_W | Source of the pushed request |
| out_bank | output | BANK_W | Bank of the pushed request |
| out_tag | output | TAG_W | Tag of the pushed request |

## Verification
Several properties are checked on every cycle. The strobes are at most one-hot. A pick only lands on a ready source. A fewest-outstanding pick never passes over a ready source with a lower count or an equal count at a lower index. A stalled cycle keeps the output source steady. A completed batch is followed by a strobe-free cycle. The random register never reaches zero.

Other behaviours can only be shown by the bench's scenarios. These are the rotation order across picks, exact batch lengths including the zero-length case, the insensitivity to `src_len` changes during a drain, the tags delivered, and the statistical presence of both rules under an intermediate probability.

// File: rtl/bs_pkg.sv
package bs_pkg;

  typedef enum logic {
    ST_PICK  = 1'b0,
    ST_DRAIN = 1'b1
  } bs_state_e;

  // index `base + off`, folded into 0..n-1 (base, off < n)
  function automatic int unsigned rot_index(int unsigned base, int unsigned off, int unsigned n);
    int unsigned s;
    s = base + off;
    return (s >= n) ? s - n : s;
  endfunction

  // successor in rotation
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // rule draw: fewest-outstanding when the random value does not exceed the threshold
  function automatic logic rule_is_sjf(logic [31:0] rnd, logic [31:0] thr);
    return rnd <= thr;
  endfunction

  // a zero-length batch still carries one request
  function automatic logic [31:0] eff_len(logic [31:0] len);
    return (len == 0) ? 32'd1 : len;
  endfunction

endpackage

// File: rtl/bs_lfsr.sv
module bs_lfsr #(
  parameter int          W     = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
    else state_q <= state_q >> 1;
  end

  assign value = state_q;

  // R5: the register must never lock up at zero
  a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/bs_sjf_sel.sv
module bs_sjf_sel #(
  parameter int NSRC  = 4,
  parameter int CNT_W = 6,
  parameter int SRC_W = 2
) (
  input  logic [NSRC-1:0]       ready,
  input  logic [NSRC*CNT_W-1:0] infl,
  output logic                  any,
  output logic [SRC_W-1:0]      sel
);

  logic [CNT_W-1:0] best_cnt;

  // strict less-than keeps the lowest index on ties (R3)
  always_comb begin
    any      = 1'b0;
    sel      = '0;
    best_cnt = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (ready[i] && (!any || infl[i*CNT_W +: CNT_W] < best_cnt)) begin
        any      = 1'b1;
        sel      = SRC_W'(i);
        best_cnt = infl[i*CNT_W +: CNT_W];
      end
    end
  end

endmodule

// File: rtl/bs_rr_sel.sv
module bs_rr_sel #(
  parameter int NSRC  = 4,
  parameter int SRC_W = 2
) (
  input  logic [NSRC-1:0]  ready,
  input  logic [SRC_W-1:0] ptr,
  output logic             any,
  output logic [SRC_W-1:0] sel
);

  import bs_pkg::*;

  int unsigned j;

  // scan downward so the nearest ready source at or after ptr wins (R4)
  always_comb begin
    any = 1'b0;
    sel = '0;
    j   = 0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      j = rot_index(int'(ptr), k, NSRC);
      if (ready[j]) begin
        any = 1'b1;
        sel = SRC_W'(j);
      end
    end
  end

endmodule

// File: rtl/batch_sched.sv
module batch_sched #(
  parameter int NSRC  = 4,
  parameter int NBANK = 4,
  parameter int LEN_W = 4,
  parameter int CNT_W = 6,
  parameter int TAG_W = 8,
  parameter int RND_W = 8,
  parameter logic [RND_W-1:0] RND_TAPS = 8'hB8,
  parameter logic [RND_W-1:0] RND_SEED = 8'h5A,
  localparam int SRC_W  = (NSRC  > 1) ? $clog2(NSRC)  : 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         src_ready,
  input  logic [NSRC*LEN_W-1:0]   src_len,
  input  logic [NSRC*CNT_W-1:0]   src_infl,
  input  logic [NSRC*BANK_W-1:0]  src_bank,
  input  logic [NSRC*TAG_W-1:0]   src_tag,
  input  logic [RND_W-1:0]        sjf_prob,
  input  logic [NBANK-1:0]        bank_full,
  output logic [NSRC-1:0]         src_deq,
  output logic                    out_valid,
  output logic [SRC_W-1:0]        out_src,
  output logic [BANK_W-1:0]       out_bank,
  output logic [TAG_W-1:0]        out_tag
);

  import bs_pkg::*;

  bs_state_e        state_q;
  logic [SRC_W-1:0] sel_q;
  logic [LEN_W-1:0] rem_q;
  logic [SRC_W-1:0] rr_ptr_q;

  // ---- rule candidates ----
  logic             sjf_any, rr_any;
  logic [SRC_W-1:0] sjf_idx, rr_idx;
  logic [RND_W-1:0] rnd;

  bs_sjf_sel #(.NSRC(NSRC), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_sjf (
    .ready (src_ready),
    .infl  (src_infl),
    .any   (sjf_any),
    .sel   (sjf_idx)
  );

  bs_rr_sel #(.NSRC(NSRC), .SRC_W(SRC_W)) u_rr (
    .ready (src_ready),
    .ptr   (rr_ptr_q),
    .any   (rr_any),
    .sel   (rr_idx)
  );

  bs_lfsr #(.W(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .value (rnd)
  );

  // ---- named events ----
  logic             use_sjf;
  logic             pick_fire;
  logic [SRC_W-1:0] pick_idx;
  logic [LEN_W-1:0] pick_len;
  logic [BANK_W-1:0] cur_bank;
  logic             stall;
  logic             beat;
  logic             last_beat;

  assign use_sjf   = rule_is_sjf(32'(rnd), 32'(sjf_prob));
  assign pick_fire = (state_q == ST_PICK) && sjf_any && rr_any;
  assign pick_idx  = use_sjf ? sjf_idx : rr_idx;
  assign pick_len  = LEN_W'(eff_len(32'(src_len[pick_idx*LEN_W +: LEN_W])));
  assign cur_bank  = src_bank[sel_q*BANK_W +: BANK_W];
  assign stall     = (state_q == ST_DRAIN) && bank_full[cur_bank];
  assign beat      = (state_q == ST_DRAIN) && !bank_full[cur_bank];
  assign last_beat = beat && (rem_q == LEN_W'(1));

  // ---- pick / drain state ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_PICK;
      sel_q    <= '0;
      rem_q    <= '0;
      rr_ptr_q <= '0;
    end else if (pick_fire) begin
      state_q  <= ST_DRAIN;
      sel_q    <= pick_idx;
      rem_q    <= pick_len;
      rr_ptr_q <= SRC_W'(wrap_inc(int'(pick_idx), NSRC));
    end else if (beat) begin
      rem_q <= rem_q - LEN_W'(1);
      if (last_beat) state_q <= ST_PICK;
    end
  end

  // ---- request stream ----
  always_comb begin
    src_deq = '0;
    if (beat) src_deq[sel_q] = 1'b1;
  end

  assign out_valid = beat;
  assign out_src   = sel_q;
  assign out_bank  = cur_bank;
  assign out_tag   = src_tag[sel_q*TAG_W +: TAG_W];

  // ---- assertions ----
  // R6: at most one source dequeued per cycle
  a_r6_deq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_deq));

  // R6: a finished batch is followed by a strobe-free pick cycle
  a_r6_gap_after_batch: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (src_deq == '0));

  // R2: a pick only lands on a ready source
  a_r2_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pick_fire |-> src_ready[pick_idx]);

  // R8: a stalled cycle keeps the draining source in place
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(out_src));

  // R3: a fewest-outstanding pick passes over no better ready source
  for (genvar g = 0; g < NSRC; g++) begin : g_sjf_chk
    a_r3_sjf_min: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_fire && use_sjf && src_ready[g]) |->
        ((src_infl[g*CNT_W +: CNT_W] > src_infl[pick_idx*CNT_W +: CNT_W]) ||
         ((src_infl[g*CNT_W +: CNT_W] == src_infl[pick_idx*CNT_W +: CNT_W]) &&
          (g >= int'(pick_idx)))));
  end

endmodule

// File: tb/sim_batch_sched.sv
`timescale 1ns/1ps
module sim_batch_sched;

  localparam int NS = 4;
  localparam int NB = 4;
  localparam int LW = 4;
  localparam int CW = 6;
  localparam int TW = 8;
  localparam int RW = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NS-1:0]     src_ready;
  logic [NS*LW-1:0]  src_len;
  logic [NS*CW-1:0]  src_infl;
  logic [NS*2-1:0]   src_bank;
  logic [NS*TW-1:0]  src_tag;
  logic [RW-1:0]     sjf_prob;
  logic [NB-1:0]     bank_full;
  logic [NS-1:0]     src_deq;
  logic              out_valid;
  logic [1:0]        out_src;
  logic [1:0]        out_bank;
  logic [TW-1:0]     out_tag;

  batch_sched #(.NSRC(NS), .NBANK(NB), .LEN_W(LW), .CNT_W(CW), .TAG_W(TW), .RND_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .src_len(src_len),
    .src_infl(src_infl), .src_bank(src_bank), .src_tag(src_tag),
    .sjf_prob(sjf_prob), .bank_full(bank_full), .src_deq(src_deq),
    .out_valid(out_valid), .out_src(out_src), .out_bank(out_bank), .out_tag(out_tag)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // source FIFO model (batches only)
  int q_len[NS][32];
  int q_head[NS];
  int q_tail[NS];
  int seq[NS];
  int infl[NS];
  int bank_of[NS];
  int full_mask = 0;
  int prob_v = 0;
  string cur_req = "R2";

  // scheduler expectation
  int m_state = 0;
  int m_sel = 0;
  int m_rem = 0;
  int m_rr = 0;
  int cand_s = 0;
  int cand_r = 0;
  int sjf_hits = 0;
  int rr_hits = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit rdy(int s);
    return q_head[s] != q_tail[s];
  endfunction

  function automatic int eff(int l);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic int head_len(int s);
    return q_len[s][q_head[s] % 32];
  endfunction

  function automatic int exp_rr();
    for (int k = 0; k < NS; k++) begin
      if (rdy((m_rr + k) % NS)) return (m_rr + k) % NS;
    end
    return -1;
  endfunction

  function automatic int exp_sjf();
    int best = -1;
    for (int i = 0; i < NS; i++)
      if (rdy(i) && (best < 0 || infl[i] < infl[best])) best = i;
    return best;
  endfunction

  task automatic push(int s, int len);
    q_len[s][q_tail[s] % 32] = len;
    q_tail[s]++;
  endtask

  task automatic drive();
    for (int s = 0; s < NS; s++) begin
      int l;
      l = rdy(s) ? head_len(s) : 0;
      // R7: scramble the draining source's length; the design must ignore it
      if (m_state == 1 && s == m_sel) l = l ^ 10;
      src_ready[s]          = rdy(s);
      src_len[s*LW +: LW]   = LW'(l);
      src_infl[s*CW +: CW]  = CW'(infl[s]);
      src_bank[s*2 +: 2]    = 2'(bank_of[s]);
      src_tag[s*TW +: TW]   = {2'(s), 6'(seq[s])};
    end
    bank_full = NB'(full_mask);
    sjf_prob  = RW'(prob_v);
  endtask

  task automatic step();
    int  exp_deq;
    bit  stalled;
    @(negedge clk);
    drive();
    #1;
    if (m_state == 1 && m_sel < 0) begin
      // R5: intermediate probability; the pick must match one rule
      if (src_deq == NS'(1 << cand_s)) begin m_sel = cand_s; sjf_hits++; end
      else if (src_deq == NS'(1 << cand_r)) begin m_sel = cand_r; rr_hits++; end
      else begin
        check(0, "R5", "pick matches a rule", src_deq, (1 << cand_s) | (1 << cand_r));
        m_sel = cand_s;
      end
      m_rem = eff(head_len(m_sel));
      m_rr  = (m_sel + 1) % NS;
    end
    stalled = (m_state == 1) && (((full_mask >> bank_of[m_sel]) & 1) != 0);
    exp_deq = (m_state == 1 && !stalled) ? (1 << m_sel) : 0;
    check(src_deq == NS'(exp_deq), stalled ? "R8" : (m_state == 1 ? "R6" : cur_req),
          "src_deq", src_deq, exp_deq);
    check(out_valid == (exp_deq != 0), stalled ? "R8" : "R6", "out_valid", out_valid, exp_deq != 0);
    if (exp_deq != 0) begin
      check(out_src == 2'(m_sel), "R9", "out_src", out_src, m_sel);
      check(out_bank == 2'(bank_of[m_sel]), "R9", "out_bank", out_bank, bank_of[m_sel]);
      check(out_tag == {2'(m_sel), 6'(seq[m_sel])}, "R9", "out_tag", out_tag,
            {2'(m_sel), 6'(seq[m_sel])});
    end
    // model the clock edge
    if (m_state == 0) begin
      int r, j;
      r = exp_rr();
      j = exp_sjf();
      if (r >= 0) begin
        m_state = 1;
        if (prob_v == 0) m_sel = r;             // R4
        else if (prob_v == 255) m_sel = j;      // R3
        else if (r == j) m_sel = r;
        else begin m_sel = -1; cand_s = j; cand_r = r; end
        if (m_sel >= 0) begin
          m_rem = eff(head_len(m_sel));
          m_rr  = (m_sel + 1) % NS;
        end
      end
    end else if (exp_deq != 0) begin
      seq[m_sel]++;
      m_rem--;
      if (m_rem == 0) begin
        q_head[m_sel]++;   // R7: only now does the next batch surface
        m_state = 0;
      end
    end
  endtask

  task automatic run_until_empty(int limit);
    for (int n = 0; n < limit; n++) begin
      bit busy = (m_state != 0);
      for (int s = 0; s < NS; s++) if (rdy(s)) busy = 1;
      if (!busy) break;
      step();
    end
    check(m_state == 0, cur_req, "drained in time", m_state, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      q_head[s] = 0; q_tail[s] = 0; seq[s] = 0; infl[s] = 0; bank_of[s] = s;
    end
    rst_n = 1'b0;
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(src_deq == '0, "R1", "deq in reset", src_deq, 0);
    check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    rst_n = 1'b1;

    // R1/R2: idle with nothing ready
    cur_req = "R2";
    repeat (4) step();

    // R4: rotation only, pointer starts at 0
    cur_req = "R4";
    prob_v = 0;
    push(2, 2); push(1, 1); push(3, 4); push(0, 3); push(0, 2); push(2, 1);
    run_until_empty(200);

    // R3: fewest-outstanding only, with a tie between sources 1 and 2
    cur_req = "R3";
    prob_v = 255;
    infl[0] = 9; infl[1] = 3; infl[2] = 3; infl[3] = 12;
    for (int s = 0; s < NS; s++) begin push(s, s + 1); push(s, 2); end
    repeat (10) step();
    infl[3] = 1;
    run_until_empty(300);

    // R8: stall on full bank; two sources share bank 1
    cur_req = "R8";
    prob_v = 0;
    bank_of[0] = 1; bank_of[1] = 1; bank_of[2] = 0; bank_of[3] = 3;
    for (int s = 0; s < NS; s++) push(s, 3);
    for (int n = 0; n < 200; n++) begin
      bit busy = (m_state != 0);
      for (int s = 0; s < NS; s++) if (rdy(s)) busy = 1;
      if (!busy) break;
      full_mask = ((n % 7) < 3) ? 2 : ((n % 11) == 5 ? 9 : 0);
      step();
    end
    full_mask = 0;
    run_until_empty(50);
    for (int s = 0; s < NS; s++) bank_of[s] = s;

    // R6: zero-length and maximum-length batches
    cur_req = "R6";
    push(1, 0); push(1, 15); push(2, 0);
    run_until_empty(100);

    // R2/R3/R4: sweep every ready subset under both forced rules
    for (int pv = 0; pv < 2; pv++) begin
      prob_v = pv ? 255 : 0;
      cur_req = pv ? "R3" : "R4";
      for (int mask = 1; mask < 16; mask++) begin
        for (int s = 0; s < NS; s++) begin
          infl[s] = (mask * 3 + s * 5) % 7;
          if ((mask >> s) & 1) push(s, (s % 3) + 1);
        end
        run_until_empty(100);
      end
    end

    // R5: intermediate probability, rules disagree on most picks
    cur_req = "R5";
    prob_v = 128;
    infl[0] = 1; infl[1] = 5; infl[2] = 9; infl[3] = 13;
    for (int r = 0; r < 40; r++) begin
      for (int s = 0; s < NS; s++) push(s, 1);
      run_until_empty(100);
    end
    check(sjf_hits > 0, "R5", "fewest-outstanding picks seen", sjf_hits, 1);
    check(rr_hits > 0, "R5", "rotation picks seen", rr_hits, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule